// File: doc/BRIEF.md
# Table-Driven Square-Wave Tune Player

The block plays a fixed tune as a one-bit square wave and runs entirely on one system clock (25 MHz in the intended build). A small table holds one period divisor per step of the tune. A tone counter runs from zero up to the current divisor minus one and then starts again. The audio bit is derived from that count, so one full output period passes per wrap. For example, a divisor of 56818 at 25 MHz gives roughly 440 Hz.

The tune does not advance every time a tone period ends. A separate duration counter, also in the system clock domain, raises a one-cycle step enable each time it rolls over. On that enable the table address moves to the next entry, so each pitch lasts for many periods and can be heard. No second clock is generated. Only one pitch sounds at any moment, and a zero divisor marks a rest.

The tune is built into the block. A play input starts and pauses it. The current step index is available at the output, for example to drive a display.

Top module: `melody_player`

## Requirements
- R1: A synchronous active-high reset sets `note_idx` to 0, sets `audio_out` low and clears both the tone counter and the duration counter. The first cycle after reset begins step 0 with both counters at zero.
- R2: While a step with a nonzero divisor D plays, the tone counter counts 0, 1, ..., D-1 and then returns to 0 on the next clock. Each wrap is one full `audio_out` period of D clocks.
- R3: The step enable occurs once every NOTE_CYCLES clocks of play time, so every step lasts exactly NOTE_CYCLES clocks while `play` is high.
- R4: On each step enable, `note_idx` increases by one. After index DEPTH-1 (31) it wraps to 0 and the tune repeats.
- R5: `audio_out` is a registered output. It is high in the clock after a cycle whose tone count is below ceil(D/2), and low in the clock after any other cycle. This gives about 50 percent duty.
- R6: A divisor of 0 marks a rest. During a rest step, `audio_out` is low.
- R7: While `play` is low, `note_idx`, the tone counter and the duration counter hold their values. `audio_out` is low in the clock after each such cycle.
- R8: When a step enable loads a new entry, the tone counter restarts from 0, so the new period starts with a high half.
- R9: Table entry i holds 0 when i mod REST_EVERY equals REST_EVERY-1. Otherwise it holds BASE_DIV + i*STEP_DIV. Entries are DIV_W (17) bits wide.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all logic is on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| play | input | 1 | High to run the tune, low to pause it |
| audio_out | output | 1 | Registered square-wave audio bit |
| note_idx | output | ADDR_W | Index of the table entry now playing |

## Verification
The bench pauses the tune in the middle of a step. A design that let the duration counter run while paused would cut the step short, and this shows up as an early `note_idx` change. The bench plays through index 31 to catch an address that stops at the end or skips index 0. It also crosses the rest entries, where a design that wraps a zero divisor through D-1 would toggle the output instead of keeping it silent. Step boundaries that fall in the middle of a tone period test the restart on a new note: without it, the new pitch starts on a stale phase and the first high half comes out short.

// File: rtl/melody_pkg.sv
package melody_pkg;

  // Divisor for step i of the built-in tune; every REST_EVERY-th step is a rest.
  function automatic int unsigned table_div(input int unsigned idx,
                                            input int unsigned base_div,
                                            input int unsigned step_div,
                                            input int unsigned rest_every);
    if ((idx % rest_every) == (rest_every - 1))
      return 0;
    else
      return base_div + idx * step_div;
  endfunction

endpackage

// File: rtl/melody_rom.sv
module melody_rom #(
  parameter int DEPTH      = 32,
  parameter int DIV_W      = 17,
  parameter int BASE_DIV   = 56818,
  parameter int STEP_DIV   = 2000,
  parameter int REST_EVERY = 8,
  localparam int ADDR_W    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DIV_W-1:0]  rd_data
);
  import melody_pkg::*;

  logic [DIV_W-1:0] rom [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_entry
    assign rom[g] = DIV_W'(table_div(g, BASE_DIV, STEP_DIV, REST_EVERY));
  end

  // Synchronous read so the table can map onto a block memory.
  always_ff @(posedge clk) begin
    rd_data <= rom[rd_addr];
  end

endmodule

// File: rtl/note_stepper.sv
module note_stepper #(
  parameter int NOTE_CYCLES = 6250000,
  parameter int DEPTH       = 32,
  localparam int ADDR_W     = $clog2(DEPTH),
  localparam int DUR_W      = $clog2(NOTE_CYCLES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              play,
  output logic              step,
  output logic [ADDR_W-1:0] note_idx,
  output logic [ADDR_W-1:0] idx_next
);
  logic [DUR_W-1:0] dur_cnt;
  logic             last_entry;

  assign step       = play && (dur_cnt == DUR_W'(NOTE_CYCLES - 1));
  assign last_entry = (note_idx == ADDR_W'(DEPTH - 1));

  always_comb begin
    if (rst)
      idx_next = '0;
    else if (step)
      idx_next = last_entry ? '0 : note_idx + 1'b1;
    else
      idx_next = note_idx;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dur_cnt  <= '0;
    end else if (play) begin
      dur_cnt  <= step ? '0 : dur_cnt + 1'b1;
    end
    note_idx <= idx_next;
  end

  p_dur_range_r3: assert property (@(posedge clk) disable iff (rst)
    dur_cnt < DUR_W'(NOTE_CYCLES));

  p_advance_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    step |=> (note_idx == (($past(note_idx) == ADDR_W'(DEPTH - 1)) ? '0 : $past(note_idx) + 1'b1)));

  p_pause_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !play |=> ($stable(note_idx) && $stable(dur_cnt)));

endmodule

// File: rtl/tone_gen.sv
module tone_gen #(
  parameter int DIV_W = 17
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             play,
  input  logic             step,
  input  logic [DIV_W-1:0] div,
  output logic             audio
);
  logic [DIV_W-1:0] tone_cnt;
  logic [DIV_W-1:0] high_len;
  logic             is_rest;
  logic             at_end;

  assign is_rest  = (div == '0);
  assign high_len = div - (div >> 1);
  assign at_end   = is_rest || (tone_cnt >= div - 1'b1);

  always_ff @(posedge clk) begin
    if (rst) begin
      tone_cnt <= '0;
      audio    <= 1'b0;
    end else if (!play) begin
      audio    <= 1'b0;
    end else begin
      audio <= !is_rest && (tone_cnt < high_len);
      if (step || at_end)
        tone_cnt <= '0;
      else
        tone_cnt <= tone_cnt + 1'b1;
    end
  end

  p_count_below_div_r2: assert property (@(posedge clk) disable iff (rst)
    (div != '0) |-> (tone_cnt < div));

  p_rest_silent_r6: assert property (@(posedge clk) disable iff (rst)
    (div == '0) |=> !audio);

  p_pause_low_r7: assert property (@(posedge clk) disable iff (rst)
    !play |=> !audio);

  p_restart_on_step_r8: assert property (@(posedge clk) disable iff (rst)
    step |=> (tone_cnt == '0));

endmodule

// File: rtl/melody_player.sv
module melody_player #(
  parameter int NOTE_CYCLES = 6250000,
  parameter int DEPTH       = 32,
  parameter int DIV_W       = 17,
  parameter int BASE_DIV    = 56818,
  parameter int STEP_DIV    = 2000,
  parameter int REST_EVERY  = 8,
  localparam int ADDR_W     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              play,
  output logic              audio_out,
  output logic [ADDR_W-1:0] note_idx
);
  logic              step;
  logic [ADDR_W-1:0] idx_next;
  logic [DIV_W-1:0]  cur_div;

  note_stepper #(
    .NOTE_CYCLES (NOTE_CYCLES),
    .DEPTH       (DEPTH)
  ) u_stepper (
    .clk      (clk),
    .rst      (rst),
    .play     (play),
    .step     (step),
    .note_idx (note_idx),
    .idx_next (idx_next)
  );

  // Reading at the next index keeps cur_div aligned with note_idx.
  melody_rom #(
    .DEPTH      (DEPTH),
    .DIV_W      (DIV_W),
    .BASE_DIV   (BASE_DIV),
    .STEP_DIV   (STEP_DIV),
    .REST_EVERY (REST_EVERY)
  ) u_rom (
    .clk     (clk),
    .rd_addr (idx_next),
    .rd_data (cur_div)
  );

  tone_gen #(
    .DIV_W (DIV_W)
  ) u_tone (
    .clk   (clk),
    .rst   (rst),
    .play  (play),
    .step  (step),
    .div   (cur_div),
    .audio (audio_out)
  );

endmodule

// File: tb/melody_player_tb.sv
`timescale 1ns/1ps
module melody_player_tb;
  localparam int N_CYC = 24;
  localparam int DEP   = 32;
  localparam int BASE  = 3;
  localparam int STEPD = 1;
  localparam int RESTE = 8;

  logic       clk = 1'b0;
  logic       rst;
  logic       play;
  logic       audio_out;
  logic [4:0] note_idx;

  int n_chk  = 0;
  int n_bad  = 0;
  bit done   = 0;

  // reference model state
  int  m_idx, m_dur, m_tone;
  bit  m_audio;
  bit  prev_rst, prev_play;
  int unsigned seed = 32'h5eed_0417;

  always #2.5 clk = ~clk;

  melody_player #(
    .NOTE_CYCLES (N_CYC),
    .DEPTH       (DEP),
    .DIV_W       (17),
    .BASE_DIV    (BASE),
    .STEP_DIV    (STEPD),
    .REST_EVERY  (RESTE)
  ) u_dut (
    .clk       (clk),
    .rst       (rst),
    .play      (play),
    .audio_out (audio_out),
    .note_idx  (note_idx)
  );

  // R9: divisor table as the requirement defines it
  function automatic int exp_div(input int i);
    return ((i % RESTE) == RESTE - 1) ? 0 : BASE + i * STEPD;
  endfunction

  task automatic model_step(input bit r, input bit p);
    int d;
    bit a;
    if (r) begin
      m_idx = 0; m_dur = 0; m_tone = 0; m_audio = 0;
    end else if (!p) begin
      m_audio = 0;
    end else begin
      d = exp_div(m_idx);
      a = (d != 0) && (m_tone < d - d / 2);
      if (m_dur == N_CYC - 1) begin
        m_dur  = 0;
        m_idx  = (m_idx + 1) % DEP;
        m_tone = 0;
      end else begin
        m_dur  = m_dur + 1;
        m_tone = (d == 0 || m_tone >= d - 1) ? 0 : m_tone + 1;
      end
      m_audio = a;
    end
  endtask

  task automatic compare();
    n_chk++;
    if (note_idx !== 5'(m_idx)) begin
      n_bad++;
      $display("FAIL R3 R4 note_idx: actual %0d expected %0d", note_idx, m_idx);
    end
    n_chk++;
    if (audio_out !== m_audio) begin
      n_bad++;
      if (prev_rst)
        $display("FAIL R1 audio after reset: actual %0b expected %0b", audio_out, m_audio);
      else if (!prev_play)
        $display("FAIL R7 audio while paused: actual %0b expected %0b", audio_out, m_audio);
      else if (exp_div(m_idx) == 0)
        $display("FAIL R6 R9 audio in rest: actual %0b expected %0b", audio_out, m_audio);
      else
        $display("FAIL R2 R5 R8 R9 audio: actual %0b expected %0b", audio_out, m_audio);
    end
  endtask

  task automatic tick(input bit r, input bit p);
    @(negedge clk);
    compare();
    rst = r; play = p;
    prev_rst = r; prev_play = p;
    model_step(r, p);
  endtask

  initial begin
    rst = 1'b1; play = 1'b0;
    prev_rst = 1'b1; prev_play = 1'b0;
    model_step(1'b1, 1'b0);
    void'($urandom(seed));

    // R1: reset state
    repeat (3) tick(1'b1, 1'b0);
    // R3 R4: full tune and wrap past index 31, through rests (R6)
    for (int i = 0; i < DEP * N_CYC + 60; i++) tick(1'b0, 1'b1);
    // R7: pause in the middle of a step, then resume
    for (int i = 0; i < 10; i++) tick(1'b0, 1'b1);
    for (int i = 0; i < 40; i++) tick(1'b0, 1'b0);
    for (int i = 0; i < 50; i++) tick(1'b0, 1'b1);
    // R1: reset in the middle of play
    tick(1'b1, 1'b1);
    tick(1'b1, 1'b0);
    // random mix of play, pause and rare reset
    for (int i = 0; i < 3000; i++) begin
      tick(($urandom % 200) == 0, ($urandom % 100) < 85);
    end
    tick(1'b0, 1'b1);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule